// File: doc/BRIEF.md
# Memory Error Capture Unit

This block sits beside the checker of a memory controller and records diagnostic state when an access reports a fault. For every accepted access it looks at the access address, the syndrome from the checker and three fault flags: correctable single-bit, uncorrectable, and parity. It also checks whether the access targets address zero. A small set of configuration inputs decides which faults count. These inputs enable checking, choose between parity and ECC, tell the block whether the memory is DRAM, turn off the zero-address check, allow single-bit faults to be captured, and freeze the capture registers on the first captured fault.

The block holds four things: the captured address, the captured syndrome, a frozen indication, and one sticky flag per fault type. Software reads these outputs and rearms the block with a one-cycle clear pulse. The access interface uses valid/ready, but the block never applies back-pressure: `acc_ready` is held high, and an access is consumed in every cycle where `acc_valid` is high. Syndrome generation and data correction happen elsewhere.

Top module: `mem_err_capture`

## Requirements
- R1: After reset, `err_addr`, `err_syndrome`, `frozen` and all four sticky flags are zero.
- R2: `acc_ready` is always 1. The outputs change at the first rising clock edge after an access is presented with `acc_valid` high, and not before that edge.
- R3: While `cfg_chk_en` is 0, the `acc_ce`, `acc_ue` and `acc_pe` inputs set no flag and load no register.
- R4: With `cfg_parity_mode` = 1, only `acc_pe` counts as a data fault. With `cfg_parity_mode` = 0 (ECC), only `acc_ce` and `acc_ue` count, and only while `cfg_mem_dram` = 1.
- R5: While `cfg_latch_sbe` = 0, a correctable fault sets `flag_ce` but loads neither `err_addr` nor `err_syndrome`, and it does not set `frozen`.
- R6: While `cfg_latch_sbe` = 1, a correctable fault loads `err_addr` and `err_syndrome` in the same way as other faults.
- R7: While `cfg_freeze` = 1, the first captured fault sets `frozen`. After that, later faults leave `err_addr` and `err_syndrome` unchanged until a clear.
- R8: While `cfg_freeze` = 0, every captured fault overwrites `err_addr` and `err_syndrome`.
- R9: While `cfg_zero_chk_dis` = 0, an access to address zero sets `flag_zero`, loads `err_addr` with 0 and loads `err_syndrome` with all zeros. While `cfg_zero_chk_dis` = 1, an access to address zero is not a fault.
- R10: When several faults occur on one access, the capture source is chosen in this order: uncorrectable first, then parity, then zero-address, then correctable. Every sticky flag that applies is still set.
- R11: A `clr_pulse` cycle clears `frozen` and all sticky flags, and leaves `err_addr` and `err_syndrome` unchanged.
- R12: Inputs presented while `acc_valid` = 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access report valid |
| acc_ready | output | 1 | Always 1; the block never stalls |
| acc_addr | input | ADDR_W | Address of the access |
| acc_syndrome | input | SYN_W | Syndrome from the checker |
| acc_ce | input | 1 | Correctable single-bit fault |
| acc_ue | input | 1 | Uncorrectable fault |
| acc_pe | input | 1 | Parity fault |
| cfg_chk_en | input | 1 | Enable data checking |
| cfg_parity_mode | input | 1 | 1 = parity, 0 = ECC |
| cfg_mem_dram | input | 1 | Memory is DRAM (required for ECC) |
| cfg_zero_chk_dis | input | 1 | Disable the zero-address check |
| cfg_latch_sbe | input | 1 | Allow correctable faults to be captured |
| cfg_freeze | input | 1 | Hold the first captured fault |
| clr_pulse | input | 1 | Clear frozen and sticky flags |
| err_addr | output | ADDR_W | Captured address |
| err_syndrome | output | SYN_W | Captured syndrome |
| frozen | output | 1 | Capture registers are frozen |
| flag_ue | output | 1 | Sticky uncorrectable fault |
| flag_pe | output | 1 | Sticky parity fault |
| flag_zero | output | 1 | Sticky zero-address fault |
| flag_ce | output | 1 | Sticky correctable fault |

## Verification
The hardest case to reach is one access that carries several faults at once while the freeze state matters. The unit cannot raise parity and ECC faults in the same mode, so the priority order can only be seen in certain combinations: an uncorrectable fault at address zero together with a correctable fault, a correctable fault at address zero with latching on, and a parity fault at address zero. To reach these, the bench clears the block, preloads a known nonzero syndrome, and then sends each combined access. The captured syndrome then shows which source won: an input value means a data fault won, and zero means the zero-address fault won. The sticky flags show that no losing fault was dropped. The freeze and clear sequence follows the same approach: capture, send a second fault, clear, and then check that the old register contents survive the clear and that a later fault is captured again.

// File: rtl/mecu_pkg.sv
package mecu_pkg;
  typedef struct packed {
    logic ue;
    logic pe;
    logic zero;
    logic ce;
  } err_evt_t;

  typedef enum logic [2:0] {
    CAP_NONE = 3'd0,
    CAP_UE   = 3'd1,
    CAP_PE   = 3'd2,
    CAP_ZERO = 3'd3,
    CAP_CE   = 3'd4
  } cap_src_t;
endpackage

// File: rtl/mecu_qualify.sv
module mecu_qualify
  import mecu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce,
  input  logic              ue,
  input  logic              pe,
  input  logic              chk_en,
  input  logic              parity_mode,
  input  logic              mem_dram,
  input  logic              zero_chk_dis,
  output err_evt_t          evt
);
  logic ecc_live;
  logic par_live;
  logic addr_is_zero;

  always_comb begin
    ecc_live     = chk_en && !parity_mode && mem_dram;
    par_live     = chk_en && parity_mode;
    addr_is_zero = (addr == '0);
    evt.ue   = valid && ecc_live && ue;
    evt.ce   = valid && ecc_live && ce;
    evt.pe   = valid && par_live && pe;
    evt.zero = valid && !zero_chk_dis && addr_is_zero;
  end
endmodule

// File: rtl/mecu_select.sv
module mecu_select
  import mecu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYN_W  = 8
) (
  input  err_evt_t          evt,
  input  logic              latch_sbe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SYN_W-1:0]  syndrome,
  output cap_src_t          src,
  output logic              cap_valid,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [SYN_W-1:0]  cap_syn
);
  always_comb begin
    if (evt.ue)                  src = CAP_UE;
    else if (evt.pe)             src = CAP_PE;
    else if (evt.zero)           src = CAP_ZERO;
    else if (evt.ce && latch_sbe) src = CAP_CE;
    else                         src = CAP_NONE;
  end

  always_comb begin
    cap_valid = (src != CAP_NONE);
    cap_addr  = addr;
    unique case (src)
      CAP_UE, CAP_PE, CAP_CE: cap_syn = syndrome;
      default:                cap_syn = '0;
    endcase
  end
endmodule

// File: rtl/mecu_capture.sv
module mecu_capture
  import mecu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              freeze,
  input  logic              cap_valid,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [SYN_W-1:0]  cap_syn,
  input  err_evt_t          evt,
  output logic [ADDR_W-1:0] addr_q,
  output logic [SYN_W-1:0]  syn_q,
  output logic              frozen_q,
  output err_evt_t          flags_q
);
  logic     held;
  logic     load;
  logic     frozen_d;
  err_evt_t flags_d;

  always_comb begin
    held     = frozen_q && !clr;
    load     = cap_valid && !(freeze && held);
    frozen_d = held || (load && freeze);
    flags_d  = (clr ? err_evt_t'('0) : flags_q) | evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      syn_q    <= '0;
      frozen_q <= 1'b0;
      flags_q  <= '0;
    end else begin
      frozen_q <= frozen_d;
      flags_q  <= flags_d;
      if (load) begin
        addr_q <= cap_addr;
        syn_q  <= cap_syn;
      end
    end
  end

  // R7
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q && freeze && !clr |=> $stable(addr_q) && $stable(syn_q));

  // R11
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && (evt == '0) |=> !frozen_q && (flags_q == '0) && $stable(addr_q) && $stable(syn_q));
endmodule

// File: rtl/mem_err_capture.sv
module mem_err_capture
  import mecu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SYN_W-1:0]  acc_syndrome,
  input  logic              acc_ce,
  input  logic              acc_ue,
  input  logic              acc_pe,
  input  logic              cfg_chk_en,
  input  logic              cfg_parity_mode,
  input  logic              cfg_mem_dram,
  input  logic              cfg_zero_chk_dis,
  input  logic              cfg_latch_sbe,
  input  logic              cfg_freeze,
  input  logic              clr_pulse,
  output logic [ADDR_W-1:0] err_addr,
  output logic [SYN_W-1:0]  err_syndrome,
  output logic              frozen,
  output logic              flag_ue,
  output logic              flag_pe,
  output logic              flag_zero,
  output logic              flag_ce
);
  err_evt_t          evt;
  err_evt_t          flags;
  cap_src_t          src;
  logic              cap_valid;
  logic [ADDR_W-1:0] cap_addr;
  logic [SYN_W-1:0]  cap_syn;

  assign acc_ready = 1'b1;

  mecu_qualify #(.ADDR_W(ADDR_W)) u_qual (
    .valid(acc_valid), .addr(acc_addr), .ce(acc_ce), .ue(acc_ue), .pe(acc_pe),
    .chk_en(cfg_chk_en), .parity_mode(cfg_parity_mode), .mem_dram(cfg_mem_dram),
    .zero_chk_dis(cfg_zero_chk_dis), .evt(evt)
  );

  mecu_select #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_sel (
    .evt(evt), .latch_sbe(cfg_latch_sbe), .addr(acc_addr), .syndrome(acc_syndrome),
    .src(src), .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_syn(cap_syn)
  );

  mecu_capture #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .freeze(cfg_freeze),
    .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_syn(cap_syn), .evt(evt),
    .addr_q(err_addr), .syn_q(err_syndrome), .frozen_q(frozen), .flags_q(flags)
  );

  assign flag_ue   = flags.ue;
  assign flag_pe   = flags.pe;
  assign flag_zero = flags.zero;
  assign flag_ce   = flags.ce;

  // R3
  chk_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !cfg_chk_en && cfg_zero_chk_dis && !clr_pulse
    |=> $stable(err_addr) && $stable(err_syndrome) && $stable(flags));

  // R5
  sbe_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ce && !acc_ue && !acc_pe && !cfg_latch_sbe && !clr_pulse
      && (cfg_zero_chk_dis || acc_addr != '0)
    |=> $stable(err_addr) && $stable(err_syndrome) && $stable(frozen));

  // R8
  overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ue && cfg_chk_en && !cfg_parity_mode && cfg_mem_dram && !cfg_freeze
    |=> err_addr == $past(acc_addr) && err_syndrome == $past(acc_syndrome));

  // R10
  src_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == CAP_CE) |-> !evt.ue && !evt.pe && !evt.zero);
endmodule

// File: tb/test_mem_err_capture.sv
module test_mem_err_capture;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic acc_ready;
  logic [AW-1:0] acc_addr = '0;
  logic [SW-1:0] acc_syndrome = '0;
  logic acc_ce = 1'b0, acc_ue = 1'b0, acc_pe = 1'b0;
  logic cfg_chk_en = 1'b1, cfg_parity_mode = 1'b0, cfg_mem_dram = 1'b1;
  logic cfg_zero_chk_dis = 1'b1, cfg_latch_sbe = 1'b1, cfg_freeze = 1'b0;
  logic clr_pulse = 1'b0;
  logic [AW-1:0] err_addr;
  logic [SW-1:0] err_syndrome;
  logic frozen, flag_ue, flag_pe, flag_zero, flag_ce;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_err_capture #(.ADDR_W(AW), .SYN_W(SW)) i_mem_err_capture (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_syndrome(acc_syndrome), .acc_ce(acc_ce), .acc_ue(acc_ue),
    .acc_pe(acc_pe), .cfg_chk_en(cfg_chk_en), .cfg_parity_mode(cfg_parity_mode),
    .cfg_mem_dram(cfg_mem_dram), .cfg_zero_chk_dis(cfg_zero_chk_dis),
    .cfg_latch_sbe(cfg_latch_sbe), .cfg_freeze(cfg_freeze), .clr_pulse(clr_pulse),
    .err_addr(err_addr), .err_syndrome(err_syndrome), .frozen(frozen),
    .flag_ue(flag_ue), .flag_pe(flag_pe), .flag_zero(flag_zero), .flag_ce(flag_ce)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int flags4();
    return {28'd0, flag_ue, flag_pe, flag_zero, flag_ce};
  endfunction

  // one access, outputs sampled at the falling edge after the capturing edge
  task automatic access(input int addr, input int syn, input bit ce, input bit ue, input bit pe);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = AW'(addr); acc_syndrome = SW'(syn);
    acc_ce = ce; acc_ue = ue; acc_pe = pe;
    @(negedge clk);
    acc_valid = 1'b0; acc_ce = 1'b0; acc_ue = 1'b0; acc_pe = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); clr_pulse = 1'b1;
    @(negedge clk); clr_pulse = 1'b0;
  endtask

  task automatic set_ecc();
    cfg_chk_en = 1; cfg_parity_mode = 0; cfg_mem_dram = 1;
    cfg_zero_chk_dis = 1; cfg_latch_sbe = 1; cfg_freeze = 0;
  endtask

  task automatic t_reset();
    check("R1", "addr", int'(err_addr), 0);
    check("R1", "syn", int'(err_syndrome), 0);
    check("R1", "frozen", int'(frozen), 0);
    check("R1", "flags", flags4(), 0);
    check("R2", "ready", int'(acc_ready), 1);
  endtask

  task automatic t_timing();
    set_ecc();
    @(negedge clk);
    acc_valid = 1; acc_addr = 16'h1234; acc_syndrome = 8'h5A; acc_ue = 1;
    #(CLK_PERIOD/2 - 1);
    check("R2", "addr before edge", int'(err_addr), 0);
    @(negedge clk);
    acc_valid = 0; acc_ue = 0;
    check("R2", "addr after edge", int'(err_addr), 16'h1234);
    check("R2", "syn after edge", int'(err_syndrome), 8'h5A);
    check("R2", "flags", flags4(), 4'b1000);
    clear();
  endtask

  task automatic t_idle();
    set_ecc(); cfg_zero_chk_dis = 0;
    @(negedge clk);
    acc_valid = 0; acc_addr = 0; acc_syndrome = 8'h11; acc_ue = 1; acc_ce = 1; acc_pe = 1;
    @(negedge clk); @(negedge clk);
    acc_ue = 0; acc_ce = 0; acc_pe = 0;
    check("R12", "addr", int'(err_addr), 16'h1234);
    check("R12", "flags", flags4(), 0);
    cfg_zero_chk_dis = 1;
  endtask

  task automatic t_chk_off();
    set_ecc(); cfg_chk_en = 0;
    access(16'h0F0F, 8'h33, 1, 1, 0);
    cfg_parity_mode = 1;
    access(16'h0F10, 8'h34, 0, 0, 1);
    check("R3", "addr", int'(err_addr), 16'h1234);
    check("R3", "syn", int'(err_syndrome), 8'h5A);
    check("R3", "flags", flags4(), 0);
  endtask

  task automatic t_mode();
    set_ecc(); cfg_parity_mode = 1;
    access(16'h2000, 8'h21, 1, 1, 0);
    check("R4", "parity mode ignores ecc", flags4(), 0);
    access(16'h2002, 8'h22, 0, 0, 1);
    check("R4", "parity addr", int'(err_addr), 16'h2002);
    check("R4", "parity flags", flags4(), 4'b0100);
    clear();
    set_ecc();
    access(16'h2004, 8'h23, 0, 0, 1);
    check("R4", "ecc ignores parity", flags4(), 0);
    cfg_mem_dram = 0;
    access(16'h2006, 8'h24, 0, 1, 0);
    check("R4", "ecc off non-dram", flags4(), 0);
    check("R4", "addr kept", int'(err_addr), 16'h2002);
  endtask

  task automatic t_sbe_nolatch();
    set_ecc(); cfg_latch_sbe = 0; cfg_freeze = 1;
    access(16'h3000, 8'h31, 1, 0, 0);
    check("R5", "addr", int'(err_addr), 16'h2002);
    check("R5", "syn", int'(err_syndrome), 8'h22);
    check("R5", "flag_ce", flags4(), 4'b0001);
    check("R5", "frozen", int'(frozen), 0);
    clear();
  endtask

  task automatic t_sbe_latch();
    set_ecc();
    access(16'h3100, 8'h41, 1, 0, 0);
    check("R6", "addr", int'(err_addr), 16'h3100);
    check("R6", "syn", int'(err_syndrome), 8'h41);
    clear();
  endtask

  task automatic t_overwrite();
    set_ecc();
    access(16'h4000, 8'h51, 0, 1, 0);
    access(16'h4001, 8'h52, 0, 1, 0);
    check("R8", "addr", int'(err_addr), 16'h4001);
    check("R8", "syn", int'(err_syndrome), 8'h52);
    check("R8", "frozen", int'(frozen), 0);
    clear();
  endtask

  task automatic t_freeze_clear();
    set_ecc(); cfg_freeze = 1;
    access(16'h5000, 8'h61, 0, 1, 0);
    check("R7", "frozen set", int'(frozen), 1);
    access(16'h5001, 8'h62, 1, 0, 0);
    check("R7", "addr held", int'(err_addr), 16'h5000);
    check("R7", "syn held", int'(err_syndrome), 8'h61);
    check("R7", "later flag set", flags4(), 4'b1001);
    clear();
    check("R11", "frozen cleared", int'(frozen), 0);
    check("R11", "flags cleared", flags4(), 0);
    check("R11", "addr kept", int'(err_addr), 16'h5000);
    check("R11", "syn kept", int'(err_syndrome), 8'h61);
    access(16'h5002, 8'h63, 0, 1, 0);
    check("R7", "rearmed addr", int'(err_addr), 16'h5002);
    clear();
  endtask

  task automatic t_zero();
    set_ecc();
    access(16'h0000, 8'h77, 0, 0, 0);
    check("R9", "disabled no flag", flags4(), 0);
    check("R9", "disabled addr", int'(err_addr), 16'h5002);
    cfg_zero_chk_dis = 0;
    access(16'h0000, 8'h77, 0, 0, 0);
    check("R9", "flag", flags4(), 4'b0010);
    check("R9", "addr", int'(err_addr), 0);
    check("R9", "syn zero", int'(err_syndrome), 0);
    clear();
  endtask

  task automatic t_priority();
    set_ecc(); cfg_zero_chk_dis = 0;
    access(16'h0000, 8'h81, 1, 1, 0);
    check("R10", "ue over zero syn", int'(err_syndrome), 8'h81);
    check("R10", "ue+zero+ce flags", flags4(), 4'b1011);
    clear();
    access(16'h0000, 8'h82, 1, 0, 0);
    check("R10", "zero over ce syn", int'(err_syndrome), 0);
    check("R10", "zero+ce flags", flags4(), 4'b0011);
    clear();
    cfg_parity_mode = 1;
    access(16'h0000, 8'h83, 0, 0, 1);
    check("R10", "pe over zero syn", int'(err_syndrome), 8'h83);
    check("R10", "pe+zero flags", flags4(), 4'b0110);
    clear();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_idle();
    t_chk_off();
    t_mode();
    t_sbe_nolatch();
    t_sbe_latch();
    t_overwrite();
    t_freeze_clear();
    t_zero();
    t_priority();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule